// File: doc/BRIEF.md
# Oversampled 8N1 Serial Receiver and Transmitter

This block is a fixed-format asynchronous serial port: one receiver and one transmitter, each sending 8 data bits with no parity and one stop bit. Both halves share a baud tick that runs at 14 times the bit rate. An 8-bit rate value sets that tick, so one bit lasts (rate + 1) × 14 clocks. The serial input passes through a two-flop synchronizer. A falling edge on the idle line starts a frame.

The receiver does not pick its first sample at the middle of the bit. It takes the sample for data bit 0 a programmable number of oversample ticks after the start edge. The 5-bit sample offset sets that count, and 20 is the usual setting. Each later bit is sampled 14 ticks after the one before it. Every received character is delivered with a one-cycle strobe, together with a framing-error flag and a break flag. After a break the receiver waits for the line to go high again.

The transmitter takes a byte through a ready/valid handshake, sends the least significant bit first and idles high. A break control input holds its output low for as long as it is set.

Top module: `hs_serial_port`

## Requirements
- R1: One bit period, for both receive and transmit, lasts (rate_i + 1) × 14 clock cycles.
- R2: The receiver assembles 8 data bits, least significant first, into rx_data_o. It reports each character with rx_valid_o high for exactly one clock.
- R3: Data bit 0 is sampled offset_i oversample ticks after the synchronized falling start edge (a value of 0 acts as 1). Each following data bit and the stop bit is sampled 14 ticks after the previous sample. With offset 7 on a 0xA5 frame, the start bit lands in bit 0, so the character reads 0x4A.
- R4: If the stop bit samples low and the data bits are not all low, the character is delivered with rx_ferr_o = 1, rx_brk_o = 0 and the sampled data.
- R5: If all 8 data bits and the stop bit sample low, the character is delivered with rx_brk_o = 1, rx_ferr_o = 0 and data 0x00. No further character is reported until the line has returned high and a new start edge arrives.
- R6: The transmitter sends a low start bit, 8 data bits least significant first, and a high stop bit. txd_o idles high.
- R7: A byte is taken only on a clock where tx_valid_i and tx_ready_o are both high. tx_ready_o stays low until the stop bit has finished. A tx_valid_i pulse while tx_ready_o is low has no effect.
- R8: While brk_i is high, txd_o is low.
- R9: After reset, txd_o is high, tx_ready_o is high and rx_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 8 | Rate value; bit period is (rate_i+1)*14 clocks |
| offset_i | input | 5 | Ticks from the start edge to the data bit 0 sample |
| brk_i | input | 1 | Force the transmit line low |
| rxd_i | input | 1 | Serial input line |
| rx_valid_o | output | 1 | One-cycle strobe for a received character |
| rx_data_o | output | 8 | Received character |
| rx_ferr_o | output | 1 | Framing-error flag of the character |
| rx_brk_o | output | 1 | Break flag of the character |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| txd_o | output | 1 | Serial output line |

## Verification
The bench changes the sample offset on a known frame. Offset 7 must shift the start bit into bit 0 and turn 0xA5 into 0x4A, so a receiver that ignores the offset, or samples at the middle of the bit, reads back the plain byte. A low stop bit after non-zero data must raise only the framing flag. An all-low frame that is held low for many bit times must produce exactly one break character with zero data. A receiver that keeps re-triggering on a stuck-low line would report extra characters. The two rate settings expose a wrong divider through lost or corrupted data on receive and misplaced bits on transmit. A tx_valid_i pulse during a busy frame checks that no byte is taken then, and the break control checks that the output is held low against data that would otherwise drive it high.

// File: rtl/hs_serial_pkg.sv
package hs_serial_pkg;
  localparam int unsigned OVS     = 14;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned RATE_W  = 8;
  localparam int unsigned OFFS_W  = 5;
  localparam int unsigned OVS_W   = $clog2(OVS + 1);
  localparam int unsigned WAIT_W  = (OFFS_W > OVS_W) ? OFFS_W : OVS_W;
  localparam int unsigned BIDX_W  = $clog2(DATA_W + 2);

  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_HOLD} rx_state_e;
endpackage

// File: rtl/hs_serial_tick.sv
module hs_serial_tick
  import hs_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && rate_i != 0 && $stable(rate_i) |=> !tick_o); // R1
endmodule

// File: rtl/hs_serial_rx.sv
module hs_serial_rx
  import hs_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic              rxd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o,
  output logic              brk_o
);
  logic [2:0]        sync_q;
  logic              line, fall;
  rx_state_e         st_q;
  logic [WAIT_W-1:0] wait_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else sync_q <= {sync_q[1:0], rxd_i};
  end

  assign line = sync_q[1];
  assign fall = sync_q[2] & ~sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      wait_q  <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (fall) begin
            st_q   <= RX_RUN;
            wait_q <= WAIT_W'(offset_i);
            bidx_q <= '0;
          end
        end
        RX_RUN: begin
          if (tick_i) begin
            if (wait_q <= WAIT_W'(1)) begin
              wait_q <= WAIT_W'(OVS);
              if (bidx_q == BIDX_W'(DATA_W)) begin
                valid_o <= 1'b1;
                brk_o   <= !line && (sh_q == '0);
                ferr_o  <= !line && (sh_q != '0);
                data_o  <= sh_q;
                st_q    <= line ? RX_IDLE : RX_HOLD;
              end else begin
                sh_q   <= {line, sh_q[DATA_W-1:1]};
                bidx_q <= bidx_q + 1'b1;
              end
            end else begin
              wait_q <= wait_q - 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (line) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  AST_RX_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(ferr_o && brk_o)); // R4
  AST_BRK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && brk_o |-> data_o == '0); // R5
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == RX_HOLD && !line |=> st_q == RX_HOLD); // R5
endmodule

// File: rtl/hs_serial_tx.sv
module hs_serial_tx
  import hs_serial_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              brk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);
  logic [DATA_W+1:0] sh_q;
  logic [BIDX_W-1:0] left_q;
  logic [OVS_W-1:0]  tcnt_q;
  logic              busy_q;
  logic              line;

  assign ready_o = !busy_q;
  assign line    = busy_q ? sh_q[0] : 1'b1;
  assign txd_o   = line & ~brk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      tcnt_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (valid_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        left_q <= BIDX_W'(DATA_W + 2);
        tcnt_q <= OVS_W'(OVS);
        busy_q <= 1'b1;
      end
    end else if (tick_i) begin
      if (tcnt_q == OVS_W'(1)) begin
        tcnt_q <= OVS_W'(OVS);
        sh_q   <= {1'b1, sh_q[DATA_W+1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == BIDX_W'(1)) busy_q <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q - 1'b1;
      end
    end
  end

  AST_TX_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o && !line); // R7
  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !brk_i |-> txd_o); // R6
  AST_TX_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_i) |-> !txd_o); // R8
endmodule

// File: rtl/hs_serial_port.sv
module hs_serial_port
  import hs_serial_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  rate_i,
  input  logic [4:0]  offset_i,
  input  logic        brk_i,
  input  logic        rxd_i,
  output logic        rx_valid_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_ferr_o,
  output logic        rx_brk_o,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  output logic        txd_o
);
  logic tick;

  hs_serial_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  hs_serial_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .offset_i (offset_i),
    .rxd_i    (rxd_i),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .ferr_o   (rx_ferr_o),
    .brk_o    (rx_brk_o)
  );

  hs_serial_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .brk_i   (brk_i),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .txd_o   (txd_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !rx_valid_o && tx_ready_o); // R9
endmodule

// File: tb/hs_serial_port_bench.sv
module hs_serial_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate = 8'd3;
  logic [4:0] offset = 5'd20;
  logic       brk = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_valid, rx_ferr, rx_brk, tx_ready, txd;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rx_cnt = 0;
  logic [7:0] cap_data = 8'h00;
  logic       cap_ferr = 1'b0;
  logic       cap_brk = 1'b0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  hs_serial_port u_hs_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate), .offset_i(offset),
    .brk_i(brk), .rxd_i(rxd), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_ferr_o(rx_ferr), .rx_brk_o(rx_brk), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .txd_o(txd)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) begin
      rx_cnt   <= rx_cnt + 1;
      cap_data <= rx_data;
      cap_ferr <= rx_ferr;
      cap_brk  <= rx_brk;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bitclk();
    return (int'(rate) + 1) * 14;
  endfunction

  task automatic drive_frame(input logic [7:0] d, input logic stop);
    @(negedge clk); rxd = 1'b0;
    repeat (bitclk()) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bitclk()) @(negedge clk);
    end
    rxd = stop;
    repeat (bitclk()) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bitclk()) @(negedge clk);
  endtask

  task automatic t_rx_ok(input string req, input logic [7:0] d, input logic [7:0] exp);
    int n0 = rx_cnt;
    drive_frame(d, 1'b1);
    chk(req, rx_cnt - n0, 1);
    chk(req, cap_data, exp);
    chk(req, {cap_ferr, cap_brk}, 2'b00);
  endtask

  task automatic t_ferr();
    int n0 = rx_cnt;
    drive_frame(8'h55, 1'b0);
    chk("R4", rx_cnt - n0, 1);
    chk("R4", cap_data, 8'h55);
    chk("R4 flags", {cap_ferr, cap_brk}, 2'b10);
  endtask

  task automatic t_break();
    int n0 = rx_cnt;
    @(negedge clk); rxd = 1'b0;
    repeat (30 * bitclk()) @(negedge clk);
    chk("R5 single", rx_cnt - n0, 1);
    chk("R5 data", cap_data, 8'h00);
    chk("R5 flags", {cap_ferr, cap_brk}, 2'b01);
    rxd = 1'b1;
    repeat (3 * bitclk()) @(negedge clk);
    chk("R5 release", rx_cnt - n0, 1);
    t_rx_ok("R5 after", 8'h81, 8'h81);
  endtask

  task automatic t_tx(input string req, input logic [7:0] d);
    logic [9:0] got;
    int guard = 0;
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R7 busy", tx_ready, 1'b0);
    while (txd !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    repeat (bitclk() / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      got[i] = txd;
      if (i == 3) begin
        tx_data = ~d; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
        repeat (bitclk() - 1) @(negedge clk);
      end else begin
        repeat (bitclk()) @(negedge clk);
      end
    end
    chk(req, got, {1'b1, d, 1'b0});
    repeat (bitclk()) @(negedge clk);
    chk("R7 ready", tx_ready, 1'b1);
    chk("R7 ignored", txd, 1'b1);
    repeat (3 * bitclk()) @(negedge clk);
    chk("R7 no extra frame", txd, 1'b1);
  endtask

  task automatic t_brk_tx();
    logic any_high = 1'b0;
    @(negedge clk); brk = 1'b1;
    tx_data = 8'hFF; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    for (int i = 0; i < 12 * bitclk(); i++) begin
      if (txd) any_high = 1'b1;
      @(negedge clk);
    end
    chk("R8", any_high, 1'b0);
    brk = 1'b0;
    @(negedge clk);
    chk("R8 release", txd, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 txd", txd, 1'b1);
    chk("R9 ready", tx_ready, 1'b1);
    chk("R9 valid", rx_valid, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_rx_ok("R2", 8'hA5, 8'hA5);
    t_rx_ok("R2", 8'h3C, 8'h3C);
    t_ferr();
    t_break();
    offset = 5'd7;
    t_rx_ok("R3", 8'hA5, 8'h4A);
    offset = 5'd20;
    rate = 8'd1;
    repeat (10) @(negedge clk);
    t_rx_ok("R1 rx", 8'h5A, 8'h5A);
    t_tx("R1 tx", 8'h96);
    rate = 8'd3;
    repeat (10) @(negedge clk);
    t_tx("R6", 8'hC3);
    t_brk_tx();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule